// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits beside the register file of a 16550-style UART and turns its individual interrupt conditions into one active-high interrupt request plus the 8-bit value returned when software reads the interrupt identification register. It watches four source groups. Receiver line errors and modem-status changes arrive as one-cycle event pulses and are held until software acknowledges them. Received data at the trigger level is a live level. A receive timeout arrives as a pulse and is held. Transmit-empty is taken from the rising edge of the holding-register-empty level.

Each source is masked by its own interrupt-enable bit. The enabled sources are ranked by fixed priority, and the highest one is encoded into the identification value. Each source is cleared by the bus access that acknowledges it. The receive FIFO, the transmit FIFO, the timeout timer, the shift registers and the address decoder stay outside the block. They reach it only as status levels, event pulses and one-cycle access strobes.

The identification value is produced combinationally from the held state. A read strobe therefore acts on the value that software sees in that same cycle. This value is the snapshot that decides whether a read of the identification register acknowledges a transmit-empty interrupt.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source active and FIFOs disabled, the identification value is 0x01 and the interrupt output is low.
- R2: Bit 0 of the identification value is 0 when an enabled source is pending and 1 otherwise. The interrupt output is high exactly when bit 0 is 0.
- R3: Priority, highest first, with the code in bits 2:1: line status 11 (value 0x06), received data 10 (0x04), transmit empty 01 (0x02), modem status 00 (0x00).
- R4: The received-data source follows the trigger-level input. A timeout pulse latches a timeout that reports 0x0C, which is received-data priority with bit 3 set. A receive-buffer read strobe clears the timeout.
- R5: A line-status event pulse latches the line-status source, and a line-status-register read strobe clears it. If a new event arrives in the same cycle as the read, the source stays pending.
- R6: A modem-status event pulse latches the modem source, and a modem-status-register read strobe clears it.
- R7: A rising edge of the transmit-empty level latches the transmit-empty source, and a transmit-holding write strobe clears it.
- R8: A read of the identification register clears the transmit-empty source only when 0x02 is the value reported in that cycle. Otherwise the source stays pending.
- R9: Bits 7:6 of the identification value are 11 while FIFOs are enabled and 00 otherwise. Bits 5:4 are always 0.
- R10: When the FIFO-enable input changes while the transmit-empty level is high, the transmit-empty source is latched at once.
- R11: Enable bit 0 gates received data and timeout, bit 1 transmit empty, bit 2 line status, and bit 3 modem status. Masked sources still latch and are reported once their enable bit is set. With all four enable bits clear, the value is 0x01 (or 0xC1 with FIFOs on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 4 | Interrupt enable bits (0 rx data, 1 tx empty, 2 line status, 3 modem) |
| fifo_on_i | input | 1 | FIFOs enabled |
| ls_event_i | input | 1 | Line-status error event pulse |
| rx_trig_i | input | 1 | Receive data at or above trigger level |
| rx_tmo_i | input | 1 | Receive timeout event pulse |
| tx_empty_i | input | 1 | Transmit holding register / FIFO empty level |
| ms_event_i | input | 1 | Modem-status delta event pulse |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_lsr_i | input | 1 | Line-status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| rd_msr_i | input | 1 | Modem-status register read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Active-high interrupt request |
| iir_o | output | 8 | Identification register value |

## Verification
The bench builds the block with its default parameters. In that build a set event wins over a same-cycle acknowledge, and a FIFO-enable toggle arms the transmit-empty source. Together these make the simultaneous set-and-read case of R5 and the immediate transmit interrupt of R10 observable at the ports. The scenarios stack several sources together and then peel them off one acknowledge at a time, so each priority level is seen. They also read the identification register while a higher source hides the transmit-empty source, and check that the hidden source survives.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 4;
  localparam int IIR_W = 8;
  localparam int ID_W  = 2;
  localparam int NSRC  = 4;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef enum logic [ID_W-1:0] {
    ID_MODEM = 2'b00,
    ID_TXE   = 2'b01,
    ID_RXDA  = 2'b10,
    ID_LINE  = 2'b11
  } irq_id_e;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    if (SET_WINS) flag_d = set_i | (flag_q & ~clr_i);
    else          flag_d = ~clr_i & (set_i | flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R5
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && SET_WINS) |=> flag_o); // R6
endmodule

// File: rtl/uart_irq_txsrc.sv
module uart_irq_txsrc #(
  parameter bit ARM_ON_FIFO_TOGGLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty_i,
  input  logic fifo_on_i,
  input  logic wr_thr_i,
  input  logic rd_iir_i,
  input  logic rpt_tx_i,
  output logic pend_o
);
  logic empty_q, fifo_q, pend_q;
  logic empty_rise, fifo_flip, arm, disarm, pend_d, pend_en;

  always_comb begin
    empty_rise = tx_empty_i & ~empty_q;
    fifo_flip  = ARM_ON_FIFO_TOGGLE & (fifo_on_i ^ fifo_q) & tx_empty_i;
    arm        = empty_rise | fifo_flip;
    disarm     = wr_thr_i | (rd_iir_i & rpt_tx_i);
    pend_en    = arm | disarm;
    pend_d     = arm | (pend_q & ~disarm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      fifo_q  <= 1'b0;
    end else begin
      empty_q <= tx_empty_i;
      fifo_q  <= fifo_on_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_TX_IIR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir_i && rpt_tx_i && !arm) |=> !pend_o); // R8
  AST_TX_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr_i && !arm) |=> !pend_o); // R7
  AST_TX_FIFO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ARM_ON_FIFO_TOGGLE && tx_empty_i && (fifo_on_i != fifo_q)) |=> pend_o); // R10
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic [IER_W-1:0] ier_i,
  input  logic             fifo_on_i,
  input  logic             ls_i,
  input  logic             rxda_i,
  input  logic             tmo_i,
  input  logic             txe_i,
  input  logic             ms_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             rpt_tx_o
);
  logic [NSRC-1:0] req;
  logic [ID_W-1:0] id;
  logic            pend, tmo_bit;

  always_comb begin
    req[ID_LINE]  = ls_i & ier_i[EN_LS];
    req[ID_RXDA]  = (rxda_i | tmo_i) & ier_i[EN_RX];
    req[ID_TXE]   = txe_i & ier_i[EN_TX];
    req[ID_MODEM] = ms_i & ier_i[EN_MS];
    id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) id = ID_W'(i);
    end
    pend     = |req;
    tmo_bit  = pend & (id == ID_RXDA) & tmo_i;
    rpt_tx_o = pend & (id == ID_TXE);
    iir_o    = {fifo_on_i, fifo_on_i, 2'b00, tmo_bit, id, ~pend};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter bit SET_WINS           = 1'b1,
  parameter bit ARM_ON_FIFO_TOGGLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier_i,
  input  logic             fifo_on_i,
  input  logic             ls_event_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             tx_empty_i,
  input  logic             ms_event_i,
  input  logic             rd_iir_i,
  input  logic             rd_lsr_i,
  input  logic             rd_rbr_i,
  input  logic             rd_msr_i,
  input  logic             wr_thr_i,
  output logic             irq_o,
  output logic [IIR_W-1:0] iir_o
);
  localparam int NFLAG = 3;
  localparam int F_LS  = 0;
  localparam int F_MS  = 1;
  localparam int F_TMO = 2;

  logic [NFLAG-1:0] f_set, f_clr, f_q;
  logic             txe_pend, rpt_tx;
  logic [IIR_W-1:0] iir;

  assign f_set = {rx_tmo_i, ms_event_i, ls_event_i};
  assign f_clr = {rd_rbr_i, rd_msr_i, rd_lsr_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uart_irq_flag #(.SET_WINS(SET_WINS)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .flag_o (f_q[g])
    );
  end

  uart_irq_txsrc #(.ARM_ON_FIFO_TOGGLE(ARM_ON_FIFO_TOGGLE)) u_txsrc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_empty_i (tx_empty_i),
    .fifo_on_i  (fifo_on_i),
    .wr_thr_i   (wr_thr_i),
    .rd_iir_i   (rd_iir_i),
    .rpt_tx_i   (rpt_tx),
    .pend_o     (txe_pend)
  );

  uart_irq_encode u_encode (
    .ier_i     (ier_i),
    .fifo_on_i (fifo_on_i),
    .ls_i      (f_q[F_LS]),
    .rxda_i    (rx_trig_i),
    .tmo_i     (f_q[F_TMO]),
    .txe_i     (txe_pend),
    .ms_i      (f_q[F_MS]),
    .iir_o     (iir),
    .rpt_tx_o  (rpt_tx)
  );

  assign iir_o = iir;
  assign irq_o = ~iir[0];

  AST_LINE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q[F_LS] && ier_i[EN_LS]) |-> (irq_o && iir_o[3:0] == 4'h6)); // R3
  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i == '0) |-> (!irq_o && iir_o[3:0] == 4'h1)); // R11
  AST_TMO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q[F_TMO] && ier_i[EN_RX] && !(f_q[F_LS] && ier_i[EN_LS])) |-> iir_o[3:0] == 4'hC); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[5:4] == 2'b00); // R9
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ier;
  logic fifo_on, ls_ev, rx_trig, rx_tmo, tx_empty, ms_ev;
  logic rd_iir, rd_lsr, rd_rbr, rd_msr, wr_thr;
  logic       irq;
  logic [7:0] iir;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_on_i(fifo_on),
    .ls_event_i(ls_ev), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
    .tx_empty_i(tx_empty), .ms_event_i(ms_ev), .rd_iir_i(rd_iir),
    .rd_lsr_i(rd_lsr), .rd_rbr_i(rd_rbr), .rd_msr_i(rd_msr),
    .wr_thr_i(wr_thr), .irq_o(irq), .iir_o(iir)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic chk_iir(input string req, input logic [7:0] exp);
    chk(req, iir, exp);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, ~exp[0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ier = 4'hF; fifo_on = 0; ls_ev = 0; rx_trig = 0; rx_tmo = 0;
    tx_empty = 0; ms_ev = 0; rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Each strobe is driven high for one cycle, then the result is sampled
  // at the following falling edge (one register stage).
  task automatic step();
    @(negedge clk);
    ls_ev = 0; rx_tmo = 0; ms_ev = 0; rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_iir("R1 reset", 8'h01);
  endtask

  task automatic t_line();
    do_reset();
    ls_ev = 1; step();
    chk_iir("R5 line set", 8'h06);
    rd_lsr = 1; step();
    chk_iir("R5 line cleared / R2", 8'h01);
    ls_ev = 1; step();
    ls_ev = 1; rd_lsr = 1; step();
    chk_iir("R5 set wins over read", 8'h06);
    rd_lsr = 1; step();
    chk_iir("R5 line cleared again", 8'h01);
  endtask

  task automatic t_modem();
    do_reset();
    ms_ev = 1; step();
    chk_iir("R6 modem set", 8'h00);
    rd_msr = 1; step();
    chk_iir("R6 modem cleared", 8'h01);
  endtask

  task automatic t_rx();
    do_reset();
    rx_trig = 1; step();
    chk_iir("R4 data available", 8'h04);
    rx_tmo = 1; step();
    chk_iir("R4 timeout", 8'h0C);
    rd_rbr = 1; step();
    chk_iir("R4 timeout cleared by rbr read", 8'h04);
    rx_trig = 0; step();
    chk_iir("R4 data below trigger", 8'h01);
  endtask

  task automatic t_priority();
    do_reset();
    ms_ev = 1; tx_empty = 1; rx_trig = 1; ls_ev = 1; step();
    chk_iir("R3 line highest", 8'h06);
    rd_lsr = 1; step();
    chk_iir("R3 data next", 8'h04);
    rx_trig = 0; step();
    chk_iir("R3 tx next", 8'h02);
    wr_thr = 1; step();
    chk_iir("R7 thr write clears / R3 modem last", 8'h00);
    rd_msr = 1; step();
    chk_iir("R3 all cleared", 8'h01);
  endtask

  task automatic t_iir_read();
    do_reset();
    tx_empty = 1; step();
    chk_iir("R7 tx empty rise", 8'h02);
    ls_ev = 1; step();
    chk_iir("R8 line hides tx", 8'h06);
    rd_iir = 1; step();
    chk_iir("R8 iir read with line reported", 8'h06);
    rd_lsr = 1; step();
    chk_iir("R8 tx survived iir read", 8'h02);
    rd_iir = 1; step();
    chk_iir("R8 iir read clears tx", 8'h01);
  endtask

  task automatic t_fifo();
    do_reset();
    fifo_on = 1; step();
    chk_iir("R9 fifo bits idle", 8'hC1);
    tx_empty = 1; step();
    chk_iir("R9 fifo bits with tx", 8'hC2);
    wr_thr = 1; step();
    chk_iir("R7 write clears in fifo mode", 8'hC1);
    fifo_on = 0; step();
    chk_iir("R10 fifo toggle arms tx", 8'h02);
  endtask

  task automatic t_mask();
    do_reset();
    ier = 4'h0; ls_ev = 1; ms_ev = 1; rx_trig = 1; step();
    chk_iir("R11 all masked", 8'h01);
    ier = 4'h8; step();
    chk_iir("R11 modem enabled alone", 8'h00);
    ier = 4'hC; step();
    chk_iir("R11 line unmasked later", 8'h06);
    ier = 4'h1; step();
    chk_iir("R11 rx enabled alone", 8'h04);
    ier = 4'h0; fifo_on = 1; step();
    chk_iir("R11 masked with fifo", 8'hC1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_line();
    t_modem();
    t_rx();
    t_priority();
    t_iir_read();
    t_fifo();
    t_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule